// File: doc/BRIEF.md
# 22 kHz Signalling Tone Gating Controller

This block makes the 22 kHz square-wave signalling carrier used on a satellite receiver's antenna feed. The carrier comes from the system clock through a parameterized divider. It is turned on and off by one of two sources. A control bit can request a continuous tone. When that bit is clear, an asynchronous modulation pin keys the carrier on and off with its logic level, so a host can encode data directly on that pin.

The carrier starts fast. When the gate opens on an idle divider, the divider restarts, so the first high half-period begins on the next clock edge. When the gate closes, the tone runs on to the end of the current half-period and then stops low, so no short pulse ever appears on the output.

The block also steers power between two outputs. One enable selects the port that carries both the supply and the tone while transmitting. The other enable selects the port that carries the supply alone while receiving. A master enable forces the tone and both port enables off.

Top module: `tone_gate_ctrl`

## Requirements
- R1: While reset is asserted, `tone_o`, `tx_port_en_o` and `rx_port_en_o` are all 0.
- R2: Each high half-period and each low half-period of a running tone lasts exactly HALF = CLK_HZ / (2*TONE_HZ) clock cycles, with integer division. The full tone period is therefore 2*HALF cycles.
- R3: While `tone_en_i` = 1 and `master_en_i` = 1, the tone runs continuously whatever the level of `mod_i`.
- R4: While `tone_en_i` = 0, `mod_i` = 1 requests the tone and `mod_i` = 0 withdraws the request. `mod_i` first passes through SYNC_STAGES (default 2) register stages.
- R5: When the tone request becomes true while the tone is idle, `tone_o` is 1 from the very next clock edge, and that first high half-period lasts the full HALF cycles.
- R6: When the request is withdrawn, the tone stops only at the next half-period boundary and then stays 0. No high or low level of the tone is shorter than HALF cycles unless `master_en_i` drops.
- R7: One clock edge after `master_en_i` = 0 is sampled, `tone_o`, `tx_port_en_o` and `rx_port_en_o` are all 0.
- R8: With `master_en_i` = 1, one clock edge after `tx_sel_i` is sampled, `tx_port_en_o` = `tx_sel_i` and `rx_port_en_o` = NOT `tx_sel_i`. The two enables are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en_i | input | 1 | Master enable; 0 forces all outputs inactive |
| tone_en_i | input | 1 | Continuous-tone request bit; has priority over the modulation pin |
| mod_i | input | 1 | Asynchronous modulation data pin; keys the tone when the continuous-tone bit is 0 |
| tx_sel_i | input | 1 | 1 routes supply and tone to the transmit port; 0 routes supply to the receive port |
| tone_o | output | 1 | Gated 22 kHz square wave |
| tx_port_en_o | output | 1 | Transmit-port enable |
| rx_port_en_o | output | 1 | Receive-port enable |

## Verification
The delicate cycles are those where a half-period boundary coincides with another event. The event may be the request being withdrawn, the master enable dropping, or the request returning just as the tone finishes. Directed sequences reach each of these once: the modulation pin is released inside a high half, and the master enable is cut while the tone runs. A long run of random changes to all four controls then makes them collide at boundaries many times. Every cycle is judged against an expected-output queue, filled by a cycle model derived from the requirements. A boundary that is resolved the wrong way shows up as a shortened or stretched level, or as a port enable that lags.

// File: rtl/tone_pkg.sv
package tone_pkg;

  // Clock cycles per half-period of the tone; never below 2 so the divider has a real count.
  function automatic int half_cycles(input int clk_hz, input int tone_hz);
    int h;
    h = clk_hz / (2 * tone_hz);
    return (h < 2) ? 2 : h;
  endfunction

  // Counter width able to hold 0 .. half-1.
  function automatic int count_bits(input int half);
    return (half > 2) ? $clog2(half) : 1;
  endfunction

endpackage

// File: rtl/tone_sync.sv
module tone_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/tone_divider.sv
module tone_divider #(
  parameter int HALF = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = tone_pkg::count_bits(HALF);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign tick_o  = run_i && at_last && !restart_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      cnt_q <= '0;
    else if (restart_i || !run_i)    cnt_q <= '0;
    else if (at_last)                cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;

  // R2: the count never leaves 0 .. HALF-1
  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < HALF);

  // R5: a restart always begins the half-period from zero
  a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/tone_gate.sv
module tone_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic master_en_i,
  input  logic req_i,
  input  logic tick_i,
  output logic start_o,
  output logic active_o,
  output logic tone_o
);
  logic active_q, phase_q;

  assign start_o  = master_en_i && req_i && !active_q;
  assign active_o = active_q;
  assign tone_o   = phase_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
    end else if (!master_en_i) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
    end else if (start_o) begin
      active_q <= 1'b1;
      phase_q  <= 1'b1;
    end else if (active_q && tick_i) begin
      if (req_i) phase_q <= ~phase_q;
      else begin
        active_q <= 1'b0;
        phase_q  <= 1'b0;
      end
    end

  // R5: the tone goes high on the edge that sees the gate open
  a_r5_fast_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> tone_o);

  // R6: the tone level changes only at a boundary, a start or a master cut
  a_r6_no_runt: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tone_o) |-> ($past(tick_i) || $past(start_o) || !$past(master_en_i)));

  // R3: with the request held, every boundary flips the tone
  a_r3_keeps_toggling: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en_i && active_q && tick_i && req_i) |=> (tone_o != $past(tone_o)));

  // R6: withdrawing the request at a boundary leaves the tone low
  a_r6_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && tick_i && !req_i) |=> !tone_o);
endmodule

// File: rtl/tone_port_steer.sv
module tone_port_steer (
  input  logic clk,
  input  logic rst_n,
  input  logic master_en_i,
  input  logic tx_sel_i,
  output logic tx_en_o,
  output logic rx_en_o
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_en_o <= 1'b0;
      rx_en_o <= 1'b0;
    end else begin
      tx_en_o <= master_en_i &&  tx_sel_i;
      rx_en_o <= master_en_i && !tx_sel_i;
    end

  // R8: the enables are never on together
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_en_o, rx_en_o}));

  // R8: with master on, the selected port follows the select bit
  a_r8_follow: assert property (@(posedge clk) disable iff (!rst_n)
    master_en_i |=> (tx_en_o == $past(tx_sel_i)) && (rx_en_o == !$past(tx_sel_i)));
endmodule

// File: rtl/tone_gate_ctrl.sv
module tone_gate_ctrl #(
  parameter int CLK_HZ      = 200_000_000,
  parameter int TONE_HZ     = 22_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master_en_i,
  input  logic tone_en_i,
  input  logic mod_i,
  input  logic tx_sel_i,
  output logic tone_o,
  output logic tx_port_en_o,
  output logic rx_port_en_o
);
  localparam int HALF = tone_pkg::half_cycles(CLK_HZ, TONE_HZ);

  // Named internal events
  logic mod_sync;
  logic gate_req;
  logic gate_start;
  logic half_tick;
  logic tone_active;

  tone_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(mod_i), .sync_o(mod_sync));

  // Continuous-tone bit wins; the pin only matters when the bit is clear
  assign gate_req = tone_en_i ? 1'b1 : mod_sync;

  tone_divider #(.HALF(HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .restart_i(gate_start),
    .run_i(tone_active), .tick_o(half_tick));

  tone_gate u_gate (
    .clk(clk), .rst_n(rst_n), .master_en_i(master_en_i), .req_i(gate_req),
    .tick_i(half_tick), .start_o(gate_start), .active_o(tone_active),
    .tone_o(tone_o));

  tone_port_steer u_steer (
    .clk(clk), .rst_n(rst_n), .master_en_i(master_en_i), .tx_sel_i(tx_sel_i),
    .tx_en_o(tx_port_en_o), .rx_en_o(rx_port_en_o));

  // R7: master off clears every output on the next edge
  a_r7_master_off: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en_i |=> (!tone_o && !tx_port_en_o && !rx_port_en_o));

  // R3: with the continuous bit on, a running tone is never stopped by the pin
  a_r3_bit_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en_i && tone_en_i && tone_active) |=> tone_active);

  // R1: reset state (immediate, during reset)
  always_comb
    if (!rst_n) a_r1_reset_quiet: assert (!tone_o && !tx_port_en_o && !rx_port_en_o);
endmodule

// File: tb/test_tone_gate_ctrl.sv
module test_tone_gate_ctrl;
  localparam int CLK_HZ  = 440_000;
  localparam int TONE_HZ = 22_000;
  localparam int SYNC    = 2;
  localparam int HALF    = (CLK_HZ / (2 * TONE_HZ) < 2) ? 2 : CLK_HZ / (2 * TONE_HZ);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_en = 1'b0, tone_en = 1'b0, mod = 1'b0, tx_sel = 1'b0;
  logic tone, tx_en, rx_en;

  always #2.5 clk = ~clk;   // 200 MHz

  tone_gate_ctrl #(.CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ), .SYNC_STAGES(SYNC)) i_tone_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .master_en_i(master_en), .tone_en_i(tone_en),
    .mod_i(mod), .tx_sel_i(tx_sel), .tone_o(tone),
    .tx_port_en_o(tx_en), .rx_port_en_o(rx_en));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic  tone;
    logic  tx;
    logic  rx;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected-value producer: a cycle model written from the requirements
  bit        m_act, m_ph;
  int        m_cnt;
  bit [SYNC-1:0] m_sync;
  always @(posedge clk) begin
    bit req;
    exp_t e;
    if (!rst_n) begin
      m_act = 0; m_ph = 0; m_cnt = 0; m_sync = '0;
    end else begin
      req = tone_en || m_sync[SYNC-1];
      if (!master_en) begin
        m_act = 0; m_ph = 0; m_cnt = 0;
      end else if (!m_act) begin
        m_cnt = 0;
        if (req) begin m_act = 1; m_ph = 1; end
      end else if (m_cnt == HALF - 1) begin
        m_cnt = 0;
        if (req) m_ph = !m_ph;
        else begin m_act = 0; m_ph = 0; end
      end else m_cnt++;
      m_sync = {m_sync[SYNC-2:0], mod};
      e.tone = m_ph;
      e.tx   = master_en && tx_sel;
      e.rx   = master_en && !tx_sel;
      e.tag  = !master_en ? "R7" : (tone_en ? "R3" : "R4");
      sb_q.push_back(e);
    end
  end

  // Monitor: compares away from the active edge
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && sb_q.size() > 0) begin
      e = sb_q.pop_front();
      check(tone == e.tone, {e.tag, "/R2/R6 tone"}, tone, e.tone);
      check(tx_en == e.tx && rx_en == e.rx, "R8 ports", {tx_en, rx_en}, {e.tx, e.rx});
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (tone === lvl && n < 10 * HALF) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n;
    cyc(3);
    check(!tone && !tx_en && !rx_en, "R1 reset", {tone, tx_en, rx_en}, 0);
    rst_n = 1'b1;
    master_en = 1'b1; tx_sel = 1'b1;
    cyc(2);
    check(tx_en && !rx_en, "R8 tx select", {tx_en, rx_en}, 2);

    // Continuous tone, fast start
    tone_en = 1'b1;
    cyc(1);
    check(tone, "R5 start next edge", tone, 1);
    run_len(1'b1, n);
    check(n == HALF, "R2 high half", n, HALF);
    run_len(1'b0, n);
    check(n == HALF, "R2 low half", n, HALF);
    for (int i = 0; i < 60; i++) begin mod = i[2]; cyc(1); end  // R3 pin ignored
    tone_en = 1'b0; mod = 1'b0;
    cyc(3 * HALF);
    check(!tone, "R6 stopped low", tone, 0);

    // Pin keying through the synchronizer
    mod = 1'b1;
    cyc(SYNC);
    check(!tone, "R4 sync delay", tone, 0);
    cyc(1);
    check(tone, "R4 pin start", tone, 1);
    mod = 1'b0;
    run_len(1'b1, n);
    check(n == HALF, "R6 no runt on release", n, HALF);
    cyc(2 * HALF);
    check(!tone, "R6 idle after release", tone, 0);

    // Receive port, then master cut while running
    tx_sel = 1'b0;
    cyc(1);
    check(rx_en && !tx_en, "R8 rx select", {tx_en, rx_en}, 1);
    tone_en = 1'b1;
    cyc(HALF / 2);
    master_en = 1'b0;
    cyc(1);
    check(!tone && !tx_en && !rx_en, "R7 master off", {tone, tx_en, rx_en}, 0);
    cyc(5);
    master_en = 1'b1;
    cyc(1);
    check(tone, "R5 restart after master", tone, 1);
    run_len(1'b1, n);
    check(n == HALF, "R5 full first half", n, HALF);

    // Random collisions at boundaries
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 6) == 0) mod = ~mod;
      if ($urandom_range(0, 40) == 0) tone_en = ~tone_en;
      if ($urandom_range(0, 50) == 0) tx_sel = ~tx_sel;
      master_en = ($urandom_range(0, 80) != 0);
      cyc(1);
    end
    cyc(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150_000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule